// File: doc/BRIEF.md
# NVRAM Image Integrity Checker

This block scans two copies of an 8 KiB non-volatile image held in a byte-wide memory and decides, for each copy, whether it can be trusted. The copies sit back to back: bank 0 at byte address 0 and bank 1 at byte address 0x2000. A single start pulse makes the block read every byte of both banks in address order, one request per clock, through a plain read port. The memory returns each byte one cycle after the request.

Each byte flows through two checksum units. The header unit produces a folded 8-bit sum over the first 16 bytes. The running unit keeps two modular sums over the body of the image. The stored signature, the stored header checksum and the stored 32-bit long checksum are captured as they stream past and are compared with the computed values. A bank that fails any comparison reports generation 0.

When both banks are done, the block raises a one-cycle done pulse. With the pulse it publishes a valid flag per bank, the generation of each bank, and which bank is newer. A bank selector uses that last bit to pick the copy to load.

Top module: `nvram_image_checker`

## Requirements
- R1: After start is sampled, rd_req_o is high for exactly 16384 consecutive cycles. rd_addr_o runs from 0 to 0x3FFF, rising by one each cycle. The data for a request is taken from rd_data_i in the following cycle. done_o rises 16386 clock edges after the edge that samples start.
- R2: A bank is valid only if its byte at offset 0 equals 0x5A.
- R3: The header sum is formed as follows. It starts as the byte at offset 0. The bytes at offsets 2 to 15 are added to it in order, and after each addition the sum is folded to low byte plus carry. The result must equal the byte at offset 1, or the bank is invalid.
- R4: The long checksum is computed over offsets 0x14 to 0x1FFF. A low sum starts at 1 and a high sum starts at 0, both modulo 65521. Each byte is added to the low sum, then the new low sum is added to the high sum. The result must equal the big-endian 32-bit word at offsets 0x10 to 0x13, with the high sum in bits 31:16, or the bank is invalid.
- R5: A bank's generation is the big-endian 32-bit word at offsets 0x14 to 0x17 when the bank is valid, and 0 when it is not.
- R6: newer_o is 1 only when bank 1's reported generation is strictly greater than bank 0's, compared unsigned. Otherwise it is 0, including when the two are equal.
- R7: done_o is a single-cycle pulse. valid_o (bit 0 for bank 0, bit 1 for bank 1), gen0_o, gen1_o and newer_o change only together with done_o and hold between pulses. All outputs are 0 after reset.
- R8: A start pulse that arrives while a scan is in flight is ignored and does not change the scan's timing.
- R9: Both running sums stay below 65521 at all times, including for images filled with 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a scan of both banks when idle |
| rd_req_o | output | 1 | Read request to the image memory |
| rd_addr_o | output | 14 | Byte address of the request |
| rd_data_i | input | 8 | Byte returned one cycle after the request |
| done_o | output | 1 | One-cycle pulse when results are published |
| valid_o | output | 2 | Per-bank integrity verdict |
| gen0_o | output | 32 | Generation of bank 0 (0 if invalid) |
| gen1_o | output | 32 | Generation of bank 1 (0 if invalid) |
| newer_o | output | 1 | 1 when bank 1 is strictly newer |

## Verification
The assertions assume that reset is held from time zero until the first few edges. They also assume that the memory answers every request in exactly the next cycle, so the address checks and the modular-sum bounds assume a gap-free stream. The bench keeps to these assumptions. It models the memory as a register that is loaded on every request edge, holds reset low from the start, and changes start only on falling edges, so that no start coincides with reset release. It fills whole banks with both varied and all-0xFF bodies, which pushes the running sums through their wrap point.

// File: rtl/nvck_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the NVRAM image checker.
// Assumes the running sums are 16 bits wide, with the modulus below 2^16.
package nvck_pkg;
    localparam int unsigned SUM_W   = 16;
    localparam int unsigned SUM_MOD = 65521;

    typedef logic [SUM_W-1:0] sum_t;

    // Add two residues and reduce the result once; both inputs must already be below SUM_MOD.
    function automatic sum_t mod_add(input sum_t a, input sum_t b);
        logic [SUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (SUM_W+1)'(SUM_MOD))
            s = s - (SUM_W+1)'(SUM_MOD);
        return s[SUM_W-1:0];
    endfunction
endpackage

// File: rtl/nvck_addr_gen.sv
`timescale 1ns/1ps
// Read request generator: after go_i, issues one request per cycle,
// covering every address from 0 up to the all-ones address.
// Assumes the scanned span is a power of two, so the last address is all ones.
module nvck_addr_gen #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    // Walk the address range once per go pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            addr_o <= '0;
        end else if (go_i) begin
            req_o  <= 1'b1;
            addr_o <= '0;
        end else if (req_o) begin
            if (addr_o == LAST_ADDR)
                req_o <= 1'b0;
            else
                addr_o <= addr_o + 1'b1;
        end
    end

    // Consecutive requests step the address by exactly one.
    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o) && !$past(go_i)) |-> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/nvck_hdr_sum.sv
`timescale 1ns/1ps
// Folded 8-bit header sum: load_i seeds the sum with a byte, and add_i
// adds a byte and folds the carry back into the low byte.
// Assumes load_i and add_i are never high together.
module nvck_hdr_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] sum_o
);
    logic [8:0] raw;
    logic [8:0] folded;

    // Add the byte to the sum and fold the carry into the low byte.
    always_comb begin
        raw    = {1'b0, sum_o} + {1'b0, byte_i};
        folded = {1'b0, raw[7:0]} + {8'b0, raw[8]};
    end

    // Seed the sum or accumulate one byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_o <= '0;
        else if (load_i)
            sum_o <= byte_i;
        else if (add_i)
            sum_o <= folded[7:0];
    end

    // The two controls come from disjoint offsets.
    assert_ctl_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && add_i));
endmodule

// File: rtl/nvck_run_sum.sv
`timescale 1ns/1ps
// Two modular running sums: the low sum accumulates the bytes, and the high
// sum accumulates each new low sum. Both are reduced on every byte.
// clr_i restores the initial values (low 1, high 0).
module nvck_run_sum
    import nvck_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       en_i,
    input  logic [7:0] byte_i,
    output sum_t       low_o,
    output sum_t       high_o
);
    sum_t low_nx;

    // Next low sum, used by both registers.
    always_comb low_nx = mod_add(low_o, {{(SUM_W-8){1'b0}}, byte_i});

    // Restart or advance both sums.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            low_o  <= sum_t'(1);
            high_o <= '0;
        end else if (en_i) begin
            low_o  <= low_nx;
            high_o <= mod_add(high_o, low_nx);
        end
    end

    // Both residues stay under the modulus.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_o < sum_t'(SUM_MOD)) && (high_o < sum_t'(SUM_MOD)));
endmodule

// File: rtl/nvram_image_checker.sv
`timescale 1ns/1ps
// NVRAM image integrity checker. Streams two back-to-back image banks from
// a memory with one-cycle read latency, checks the signature, the header
// sum and the long sum of each bank, and publishes per-bank validity,
// generations and the newer bank with a single done pulse.
// Assumes IMG_BYTES is a power of two and GEN_W is a multiple of 8.
module nvram_image_checker
    import nvck_pkg::*;
#(
    parameter int         IMG_BYTES = 8192,
    parameter int         HDR_BYTES = 16,
    parameter int         LSUM_OFF  = 16,
    parameter int         SUM_START = 20,
    parameter int         GEN_W     = 32,
    parameter logic [7:0] SIG_VALUE = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    output logic                  rd_req_o,
    output logic [$clog2(IMG_BYTES):0] rd_addr_o,
    input  logic [7:0]            rd_data_i,
    output logic                  done_o,
    output logic [1:0]            valid_o,
    output logic [GEN_W-1:0]      gen0_o,
    output logic [GEN_W-1:0]      gen1_o,
    output logic                  newer_o
);
    localparam int OFF_W    = $clog2(IMG_BYTES);
    localparam int ADDR_W   = OFF_W + 1;
    localparam int GEN_B    = GEN_W / 8;
    localparam int LSUM_W   = 2 * SUM_W;
    localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(IMG_BYTES - 1);
    localparam logic [OFF_W-1:0] OFF_CK    = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_HADD  = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_HEND  = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] OFF_LS    = OFF_W'(LSUM_OFF);
    localparam logic [OFF_W-1:0] OFF_LSEND = OFF_W'(LSUM_OFF + 4);
    localparam logic [OFF_W-1:0] OFF_SUM   = OFF_W'(SUM_START);
    localparam logic [OFF_W-1:0] OFF_GEND  = OFF_W'(SUM_START + GEN_B);

    // Read pipeline: a request issued in one cycle returns data in the next.
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [OFF_W-1:0]  off;
    logic              bank;
    logic              busy;
    logic              go;

    // Per-bank capture and verdict state.
    logic [7:0]        sig_q;
    logic [7:0]        ck_q;
    logic [LSUM_W-1:0] lsum_q;
    logic [GEN_W-1:0]  gen_q;
    logic              fin_q;
    logic              fin_bank_q;
    logic              b0_ok_q;
    logic [GEN_W-1:0]  b0_gen_q;

    logic [7:0]        hdr_sum;
    sum_t              run_lo;
    sum_t              run_hi;
    logic              bank_ok;
    logic [GEN_W-1:0]  bank_gen;

    always_comb begin
        off  = pend_addr_q[OFF_W-1:0];
        bank = pend_addr_q[OFF_W];
        busy = rd_req_o | pend_q | fin_q;
        go   = start_i & ~busy;
    end

    nvck_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .req_o  (rd_req_o),
        .addr_o (rd_addr_o)
    );

    nvck_hdr_sum u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pend_q && off == '0),
        .add_i  (pend_q && off >= OFF_HADD && off < OFF_HEND),
        .byte_i (rd_data_i),
        .sum_o  (hdr_sum)
    );

    nvck_run_sum u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pend_q && off == '0),
        .en_i   (pend_q && off >= OFF_SUM),
        .byte_i (rd_data_i),
        .low_o  (run_lo),
        .high_o (run_hi)
    );

    // Track which request the returning byte belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            pend_q      <= rd_req_o;
            pend_addr_q <= rd_addr_o;
        end
    end

    // Capture the stored header fields as they stream past.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q  <= '0;
            ck_q   <= '0;
            lsum_q <= '0;
            gen_q  <= '0;
        end else if (pend_q) begin
            if (off == '0)
                sig_q <= rd_data_i;
            if (off == OFF_CK)
                ck_q <= rd_data_i;
            if (off >= OFF_LS && off < OFF_LSEND)
                lsum_q <= {lsum_q[LSUM_W-9:0], rd_data_i};
            if (off >= OFF_SUM && off < OFF_GEND)
                gen_q <= {gen_q[GEN_W-9:0], rd_data_i};
        end
    end

    // Mark the cycle after a bank's last byte has entered the units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q      <= 1'b0;
            fin_bank_q <= 1'b0;
        end else begin
            fin_q      <= pend_q && off == OFF_LAST;
            fin_bank_q <= bank;
        end
    end

    // Verdict for the bank that just finished.
    always_comb begin
        bank_ok  = (sig_q == SIG_VALUE) && (ck_q == hdr_sum) &&
                   (lsum_q == {run_hi, run_lo});
        bank_gen = bank_ok ? gen_q : '0;
    end

    // Hold bank 0's verdict, then publish both banks together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_ok_q  <= 1'b0;
            b0_gen_q <= '0;
            done_o   <= 1'b0;
            valid_o  <= '0;
            gen0_o   <= '0;
            gen1_o   <= '0;
            newer_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (fin_q && !fin_bank_q) begin
                b0_ok_q  <= bank_ok;
                b0_gen_q <= bank_gen;
            end
            if (fin_q && fin_bank_q) begin
                done_o  <= 1'b1;
                valid_o <= {bank_ok, b0_ok_q};
                gen0_o  <= b0_gen_q;
                gen1_o  <= bank_gen;
                newer_o <= bank_gen > b0_gen_q;
            end
        end
    end

    // Done lasts exactly one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Published results only move with done.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(valid_o) && $stable(gen0_o) && $stable(gen1_o) && $stable(newer_o)));

    // An invalid bank never reports a non-zero generation.
    assert_gen_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((valid_o[0] || gen0_o == '0) && (valid_o[1] || gen1_o == '0)));

    // The newer flag agrees with the published generations.
    assert_newer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (newer_o == (gen1_o > gen0_o)));

    // A start during a scan does not restart the address stream.
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && start_i && rd_addr_o != '1) |=> (rd_req_o && rd_addr_o != '0));
endmodule

// File: tb/sim_nvram_image_checker.sv
`timescale 1ns/1ps
module sim_nvram_image_checker;
    localparam int IMG = 8192;
    localparam int MOD = 65521;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_req_o;
    logic [13:0] rd_addr_o;
    logic [7:0]  rd_data_i = 8'h00;
    logic        done_o;
    logic [1:0]  valid_o;
    logic [31:0] gen0_o, gen1_o;
    logic        newer_o;

    int total = 0;
    int bad = 0;

    logic [7:0] mem [0:2*IMG-1];

    always #2.5 clk = ~clk;

    nvram_image_checker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .done_o(done_o), .valid_o(valid_o), .gen0_o(gen0_o), .gen1_o(gen1_o),
        .newer_o(newer_o)
    );

    // One-cycle read latency memory model.
    always @(posedge clk) if (rd_req_o) rd_data_i <= mem[rd_addr_o];

    // Vector: gen0, gen1, corrupt0, corrupt1, fill (0 = pattern), exp valid, exp newer.
    // Corrupt codes: 0 none, 1 bad signature, 2 bad header sum byte,
    // 3 body byte flipped, 4 stored long sum flipped, 5 name byte flipped.
    localparam int NV = 7;
    localparam logic [82:0] VECS [0:NV-1] = '{
        {32'd5,          32'd9,          4'd0, 4'd0, 8'h00, 2'b11, 1'b1},
        {32'd9,          32'd5,          4'd0, 4'd0, 8'h00, 2'b11, 1'b0},
        {32'd7,          32'd7,          4'd0, 4'd0, 8'h00, 2'b11, 1'b0},
        {32'd3,          32'd100,        4'd0, 4'd1, 8'h00, 2'b01, 1'b0},
        {32'd50,         32'd2,          4'd2, 4'd0, 8'h00, 2'b10, 1'b1},
        {32'h8000_0000,  32'd1,          4'd3, 4'd4, 8'hFF, 2'b00, 1'b0},
        {32'd1,          32'hFFFF_FFFF,  4'd5, 4'd0, 8'hFF, 2'b10, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input int b, input logic [31:0] gen, input logic [7:0] fill, input int cor);
        int base;
        int s;
        int lo;
        int hi;
        base = b * IMG;
        for (int i = 0; i < IMG; i++)
            mem[base+i] = (fill == 8'h00) ? 8'((i*7 + 3 + b) & 255) : fill;
        mem[base+0] = 8'h5A;
        mem[base+2] = 8'h02;
        mem[base+3] = 8'h00;
        for (int i = 4; i < 16; i++) mem[base+i] = 8'(65 + i);
        mem[base+20] = gen[31:24];
        mem[base+21] = gen[23:16];
        mem[base+22] = gen[15:8];
        mem[base+23] = gen[7:0];
        s = mem[base+0];
        for (int i = 2; i < 16; i++) begin
            s = s + mem[base+i];
            s = (s & 255) + (s >> 8);
        end
        mem[base+1] = 8'(s);
        lo = 1;
        hi = 0;
        for (int i = 20; i < IMG; i++) begin
            lo = (lo + mem[base+i]) % MOD;
            hi = (hi + lo) % MOD;
        end
        mem[base+16] = 8'(hi >> 8);
        mem[base+17] = 8'(hi);
        mem[base+18] = 8'(lo >> 8);
        mem[base+19] = 8'(lo);
        case (cor)
            1: mem[base+0]    = 8'hA5;
            2: mem[base+1]    = mem[base+1] ^ 8'h01;
            3: mem[base+6844] = mem[base+6844] ^ 8'h40;
            4: mem[base+18]   = mem[base+18] ^ 8'h01;
            5: mem[base+8]    = mem[base+8] ^ 8'h10;
            default: ;
        endcase
    endtask

    // Run one scan; optionally pulse start again mid-scan. Returns edge count to done.
    task automatic scan(input bit mid_start, output int n);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
            start_i = (mid_start && n == 100);
            if (n == 101) start_i = 1'b0;
        end
        start_i = 1'b0;
    endtask

    initial begin
        int n;
        logic [31:0] g0, g1, e0, e1;
        logic [1:0]  ev;
        repeat (4) @(negedge clk);
        // R7: reset state.
        chk(done_o == 0 && rd_req_o == 0, "R7 reset done/req", {30'd0, done_o, rd_req_o}, 0);
        chk(valid_o == 0 && gen0_o == 0 && gen1_o == 0 && newer_o == 0, "R7 reset outputs",
            gen0_o | gen1_o | {29'd0, valid_o, newer_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            g0 = VECS[v][82:51];
            g1 = VECS[v][50:19];
            build(0, g0, VECS[v][10:3], int'(VECS[v][18:15]));
            build(1, g1, VECS[v][10:3], int'(VECS[v][14:11]));
            ev = VECS[v][2:1];
            e0 = ev[0] ? g0 : 32'd0;
            e1 = ev[1] ? g1 : 32'd0;
            scan(v == 0, n);
            if (n >= 20000) begin
                chk(0, "R1 watchdog on done", n, 16386);
            end else begin
                chk(n == 16386, (v == 0) ? "R8 latency with mid-scan start" : "R1 scan latency", n, 16386);
                chk(valid_o == ev, "R2 R3 R4 bank verdicts", {30'd0, valid_o}, {30'd0, ev});
                chk(gen0_o == e0, "R5 bank0 generation", gen0_o, e0);
                chk(gen1_o == e1, "R5 bank1 generation", gen1_o, e1);
                chk(newer_o == VECS[v][0], "R6 newer bank", {31'd0, newer_o}, {31'd0, VECS[v][0]});
                @(negedge clk);
                chk(done_o == 0, "R7 done single cycle", {31'd0, done_o}, 0);
                repeat (3) @(negedge clk);
                chk(valid_o == ev && gen1_o == e1 && rd_req_o == 0, "R7 R8 outputs held, no rescan",
                    {29'd0, rd_req_o, valid_o}, {30'd0, ev});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule